// File: doc/BRIEF.md
# Step-Driven Multi-Mode Divider

This block divides a 16-bit or 32-bit dividend by a 16-bit divisor through a fixed series of externally issued step pulses. It does not run by itself. A start strobe captures the operands and the mode. After that, every cycle in which the step input is high moves the operation forward by one stage. The first step prepares operand magnitudes and signs. The next sixteen steps each produce one quotient bit by restoring shift-subtract. The eighteenth step applies the sign correction and writes the two result registers. With one start cycle and eighteen back-to-back steps, a complete divide takes nineteen cycles.

Five kinds of division share the same datapath: unsigned and signed 16/16, unsigned and signed 32/16, and a signed Q15 fractional form. The 32-bit forms take the dividend from two 16-bit words. Step is allowed to drop for any number of cycles between stages, so the operation can stall, for example while the surrounding pipeline serves an interrupt, and then carry on with no loss. The surrounding logic is responsible for issuing exactly eighteen steps. Signed results truncate toward zero.

Top module: `stepdiv_top`

## Requirements
- R1: The operands and the mode are sampled only in the cycle where start is high. Changes to dvd_hi, dvd_lo, divisor or mode after that cycle have no effect on the result.
- R2: The mode encoding is 0 = unsigned 16/16 (dvd_lo / divisor), 1 = signed 16/16, 2 = unsigned 32/16, 3 = signed 32/16, 4 = signed fractional. Codes 5 to 7 behave as code 0.
- R3: The signed modes truncate the quotient toward zero, and the remainder takes the sign of the dividend. For mode 1, q = lo/d and r = lo - q*d, with both operands in two's complement.
- R4: Modes 2 and 3 divide {dvd_hi, dvd_lo}, where dvd_hi is the upper half. The results are exact whenever the true quotient fits in 16 bits (unsigned) or lies in -32767..32767 (signed).
- R5: Mode 4 divides the Q15 value dvd_lo by the Q15 divisor. The signed dividend dvd_lo*2^15 is divided by divisor with R3 rounding. The result is exact when |dvd_lo| < |divisor|.
- R6: done goes high in the cycle that follows the 18th accepted step pulse. After 17 or fewer steps, done stays low.
- R7: A cycle with step low and start low leaves the operation unchanged. Any number of idle cycles between steps gives the same result as back-to-back steps.
- R8: quotient and remainder keep their previous values until the completing step. Both then update on that same clock edge.
- R9: Once done is high, further step pulses have no effect: done, quotient, remainder and div_zero stay unchanged until the next start.
- R10: Start restarts the operation from its first stage, even while a divide is in progress. It clears done and div_zero in the next cycle, and a step that is high in the same cycle as start is not counted.
- R11: A zero divisor sets div_zero together with done on completion. div_zero never goes high while done is low.
- R12: After reset, done = 0, div_zero = 0, quotient = 0 and remainder = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures operands and mode and begins a new divide |
| step | input | 1 | Advances the divide by one stage |
| mode | input | 3 | Division kind (see R2) |
| dvd_hi | input | 16 | Upper dividend word (32/16 modes only) |
| dvd_lo | input | 16 | Lower dividend word, or the whole dividend in 16-bit and fractional modes |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient result register |
| remainder | output | 16 | Remainder result register |
| done | output | 1 | Result registers hold the result of the last divide |
| div_zero | output | 1 | The last completed divide had a zero divisor |

## Verification
The case that is hardest to reach from the ports is a divide stalled part-way through its bit stages for a varying number of cycles, in every mode, while the operand inputs keep changing. The bench reaches it by putting a random number of idle cycles in front of every step and by scrambling the operand and mode inputs right after each start. Constructed random operands keep every quotient in range, so that each stalled run still has one exact expected result. Directed sequences cover the remaining paths: a restart after seven steps, a step issued together with start, an interrupted step count, and extra steps issued after completion.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
  localparam int unsigned WORD  = 16;
  localparam int unsigned ITER  = WORD;
  localparam int unsigned STEPS = ITER + 2;

  typedef enum logic [2:0] {
    MD_U16  = 3'd0,
    MD_S16  = 3'd1,
    MD_U32  = 3'd2,
    MD_S32  = 3'd3,
    MD_FRAC = 3'd4
  } mode_e;

  typedef struct packed {
    logic [2*WORD-1:0] mag_n;
    logic [WORD-1:0]   mag_d;
    logic              neg_q;
    logic              neg_r;
    logic              dz;
  } prep_t;

  typedef struct packed {
    logic [WORD-1:0] r;
    logic [WORD-1:0] q;
  } pair_t;

  // Convert raw operands into magnitudes plus the two sign-fix flags
  function automatic prep_t prep_operands(logic [2:0] md, logic [WORD-1:0] hi,
                                          logic [WORD-1:0] lo, logic [WORD-1:0] d);
    prep_t p;
    logic [2*WORD-1:0] num;
    logic sgn;
    case (md)
      MD_S16:  begin num = {{WORD{lo[WORD-1]}}, lo};               sgn = 1'b1; end
      MD_U32:  begin num = {hi, lo};                               sgn = 1'b0; end
      MD_S32:  begin num = {hi, lo};                               sgn = 1'b1; end
      MD_FRAC: begin num = {lo[WORD-1], lo, {(WORD-1){1'b0}}};     sgn = 1'b1; end
      default: begin num = {{WORD{1'b0}}, lo};                     sgn = 1'b0; end
    endcase
    p.neg_r = sgn & num[2*WORD-1];
    p.neg_q = sgn & (num[2*WORD-1] ^ d[WORD-1]);
    p.mag_n = p.neg_r ? (~num + 1'b1) : num;
    p.mag_d = (sgn & d[WORD-1]) ? (~d + 1'b1) : d;
    p.dz    = (d == '0);
    return p;
  endfunction

  // One restoring shift-subtract stage
  function automatic pair_t shift_sub(logic [WORD-1:0] r, logic [WORD-1:0] q,
                                      logic [WORD-1:0] d);
    pair_t o;
    logic [WORD:0] trial;
    logic [WORD:0] diff;
    trial = {r, q[WORD-1]};
    diff  = trial - {1'b0, d};
    if (trial >= {1'b0, d}) begin
      o.r = diff[WORD-1:0];
      o.q = {q[WORD-2:0], 1'b1};
    end else begin
      o.r = trial[WORD-1:0];
      o.q = {q[WORD-2:0], 1'b0};
    end
    return o;
  endfunction

  function automatic logic [WORD-1:0] apply_sign(logic [WORD-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction
endpackage

// File: rtl/stepdiv_seq.sv
module stepdiv_seq #(
  parameter int unsigned NSTEP = stepdiv_pkg::STEPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic load_fire,
  output logic iter_fire,
  output logic finish_fire
);
  localparam int unsigned IW = $clog2(NSTEP);
  localparam logic [IW-1:0] LAST = IW'(NSTEP - 1);

  logic          busy;
  logic [IW-1:0] idx;
  logic          adv;

  assign adv         = step & busy & ~start;
  assign load_fire   = adv & (idx == '0);
  assign finish_fire = adv & (idx == LAST);
  assign iter_fire   = adv & ~load_fire & ~finish_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (adv) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && !start) |=> (busy && $stable(idx)));

  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_fire, iter_fire, finish_fire}));

  // R10
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && idx == '0));
endmodule

// File: rtl/stepdiv_dp.sv
module stepdiv_dp #(
  parameter int unsigned W = stepdiv_pkg::WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load_fire,
  input  logic         iter_fire,
  input  logic [2:0]   mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] res_q,
  output logic [W-1:0] res_r,
  output logic         res_dz
);
  import stepdiv_pkg::*;

  logic [2:0]   op_md;
  logic [W-1:0] op_hi, op_lo, op_d;
  logic [W-1:0] ar, aq, dv;
  logic         nq, nr, dz;
  prep_t        prep;
  pair_t        nxt;

  assign prep = prep_operands(op_md, op_hi, op_lo, op_d);
  assign nxt  = shift_sub(ar, aq, dv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_md <= '0;
      op_hi <= '0;
      op_lo <= '0;
      op_d  <= '0;
    end else if (start) begin
      op_md <= mode;
      op_hi <= dvd_hi;
      op_lo <= dvd_lo;
      op_d  <= divisor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar <= '0;
      aq <= '0;
      dv <= '0;
      nq <= 1'b0;
      nr <= 1'b0;
      dz <= 1'b0;
    end else if (load_fire) begin
      ar <= prep.mag_n[2*W-1:W];
      aq <= prep.mag_n[W-1:0];
      dv <= prep.mag_d;
      nq <= prep.neg_q;
      nr <= prep.neg_r;
      dz <= prep.dz;
    end else if (iter_fire) begin
      ar <= nxt.r;
      aq <= nxt.q;
    end
  end

  assign res_q  = apply_sign(aq, nq);
  assign res_r  = apply_sign(ar, nr);
  assign res_dz = dz;

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_fire && ar < dv) |=> (ar < dv));

  // R1
  op_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(op_lo) && $stable(op_hi) && $stable(op_d) && $stable(op_md)));
endmodule

// File: rtl/stepdiv_top.sv
module stepdiv_top #(
  parameter int unsigned W     = stepdiv_pkg::WORD,
  parameter int unsigned NSTEP = stepdiv_pkg::STEPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic [2:0]   mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         div_zero
);
  logic         load_fire, iter_fire, finish_fire;
  logic [W-1:0] res_q, res_r;
  logic         res_dz;

  stepdiv_seq #(.NSTEP(NSTEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .load_fire(load_fire), .iter_fire(iter_fire), .finish_fire(finish_fire)
  );

  stepdiv_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_fire(load_fire), .iter_fire(iter_fire),
    .mode(mode), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .res_q(res_q), .res_r(res_r), .res_dz(res_dz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
    end else if (start) begin
      done      <= 1'b0;
      div_zero  <= 1'b0;
    end else if (finish_fire) begin
      quotient  <= res_q;
      remainder <= res_r;
      done      <= 1'b1;
      div_zero  <= res_dz;
    end
  end

  // R6
  done_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_fire |=> ($stable(quotient) && $stable(remainder)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(div_zero)));

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !div_zero));

  // R11
  dz_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> done);
endmodule

// File: tb/stepdiv_top_bench.sv
module stepdiv_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic [15:0] quotient, remainder;
  logic        done, div_zero;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  stepdiv_top u_stepdiv_top (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .mode(mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .div_zero(div_zero)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference: longint division truncates toward zero, % follows dividend sign
  function automatic void model(int md, logic [15:0] hi, logic [15:0] lo, logic [15:0] d,
                                output logic [15:0] q, output logic [15:0] r);
    longint n, dd;
    case (md)
      1: begin n = longint'($signed(lo)); dd = longint'($signed(d)); end
      2: begin n = longint'({32'b0, hi, lo}); dd = longint'({48'b0, d}); end
      3: begin n = longint'($signed({hi, lo})); dd = longint'($signed(d)); end
      4: begin n = longint'($signed(lo)) * 32768; dd = longint'($signed(d)); end
      default: begin n = longint'({48'b0, lo}); dd = longint'({48'b0, d}); end
    endcase
    q = 16'(n / dd);
    r = 16'(n % dd);
  endfunction

  task automatic kick(int md, logic [15:0] hi, logic [15:0] lo, logic [15:0] d, bit with_step);
    @(negedge clk);
    start = 1'b1; step = with_step;
    mode = 3'(md); dvd_hi = hi; dvd_lo = lo; divisor = d;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    mode = 3'($urandom); dvd_hi = 16'($urandom); dvd_lo = 16'($urandom); divisor = 16'($urandom);
  endtask

  task automatic pulses(int n, int gapmax);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % (gapmax + 1)) @(negedge clk);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
    end
  endtask

  task automatic run_check(string tag, int md, logic [15:0] hi, logic [15:0] lo,
                           logic [15:0] d, int gapmax);
    logic [15:0] eq, er;
    model(md, hi, lo, d, eq, er);
    kick(md, hi, lo, d, 1'b0);
    pulses(18, gapmax);
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " quotient"}, 32'(quotient), 32'(eq));
    chk({tag, " remainder"}, 32'(remainder), 32'(er));
  endtask

  function automatic logic [15:0] nz16();
    logic [15:0] v;
    v = 16'($urandom);
    if (v == 16'd0) v = 16'd1;
    return v;
  endfunction

  initial begin
    logic [15:0] d, lo, hi, q0, r0;
    longint md, mq, mr, mn, n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 div_zero", 32'(div_zero), 32'd0);
    chk("R12 quotient", 32'(quotient), 32'd0);
    chk("R12 remainder", 32'(remainder), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_check("R2 u16 max/1", 0, 16'h0, 16'hFFFF, 16'h0001, 0);
    run_check("R2 reserved code 6 acts as u16", 6, 16'h1234, 16'd1000, 16'd7, 0);
    run_check("R3 s16 -7/2", 1, 16'h0, 16'hFFF9, 16'h0002, 0);
    run_check("R3 s16 7/-2", 1, 16'h0, 16'h0007, 16'hFFFE, 1);
    run_check("R4 s32 neg", 3, 16'hFFFF, 16'h8001, 16'h0100, 1);
    run_check("R4 u32 big", 2, 16'hFFFE, 16'h0001, 16'hFFFF, 0);
    run_check("R5 frac 0.5/~1", 4, 16'h0, 16'h4000, 16'h7FFF, 0);
    run_check("R5 frac -0.25/0.5", 4, 16'h0, 16'hE000, 16'h4000, 2);
    run_check("R5 frac x/-1.0", 4, 16'h0, 16'h7FFF, 16'h8000, 0);

    // Random per mode, random stalls between steps (R1, R7 via scrambled inputs and gaps)
    for (int m = 0; m < 5; m++) begin
      for (int t = 0; t < 30; t++) begin
        hi = 16'h0; lo = 16'($urandom); d = nz16();
        case (m)
          1: if (lo == 16'h8000 && d == 16'hFFFF) d = 16'd3;
          2: begin
            mq = longint'($urandom % 65536); mr = longint'($urandom) % longint'(d);
            mn = mq * longint'(d) + mr;
            {hi, lo} = 32'(mn);
          end
          3: begin
            md = longint'($signed(d)); if (md < 0) md = -md;
            mq = longint'($urandom % 32768); mr = longint'($urandom) % md;
            mn = mq * md + mr;
            n = ($urandom % 2 == 1) ? -mn : mn;
            {hi, lo} = 32'(n);
          end
          4: begin
            md = longint'($signed(d)); if (md < 0) md = -md;
            mn = longint'($urandom) % md;
            n = ($urandom % 2 == 1) ? -mn : mn;
            lo = 16'(n);
          end
          default: ;
        endcase
        run_check($sformatf("R1/R7 random mode %0d", m), m, hi, lo, d, 3);
      end
    end

    // R6: 17 steps leave done low, results held (R8), 18th completes
    q0 = quotient; r0 = remainder;
    kick(0, 16'h0, 16'd500, 16'd9, 1'b0);
    chk("R10 done cleared after start", 32'(done), 32'd0);
    pulses(17, 1);
    chk("R6 done low after 17 steps", 32'(done), 32'd0);
    chk("R8 quotient held mid-divide", 32'(quotient), 32'(q0));
    chk("R8 remainder held mid-divide", 32'(remainder), 32'(r0));
    repeat (5) @(negedge clk);
    chk("R7 stall keeps done low", 32'(done), 32'd0);
    pulses(1, 0);
    chk("R6 done after 18th step", 32'(done), 32'd1);
    chk("R6 quotient", 32'(quotient), 32'd55);
    chk("R6 remainder", 32'(remainder), 32'd5);

    // R9: extra steps ignored
    pulses(3, 1);
    chk("R9 done kept", 32'(done), 32'd1);
    chk("R9 quotient kept", 32'(quotient), 32'd55);
    chk("R9 remainder kept", 32'(remainder), 32'd5);

    // R10: restart mid-divide with new operands
    kick(1, 16'h0, 16'hFF38, 16'd7, 1'b0);
    pulses(7, 1);
    kick(0, 16'h0, 16'd1000, 16'd3, 1'b0);
    pulses(18, 1);
    chk("R10 restart quotient", 32'(quotient), 32'd333);
    chk("R10 restart remainder", 32'(remainder), 32'd1);

    // R10: step during start not counted
    kick(0, 16'h0, 16'd77, 16'd10, 1'b1);
    pulses(17, 0);
    chk("R10 step with start not counted", 32'(done), 32'd0);
    pulses(1, 0);
    chk("R10 done after 18 real steps", 32'(done), 32'd1);
    chk("R10 quotient", 32'(quotient), 32'd7);

    // R11: zero divisor, then cleared by start
    kick(3, 16'h0001, 16'h0000, 16'h0000, 1'b0);
    pulses(18, 2);
    chk("R11 div_zero set", 32'(div_zero), 32'd1);
    chk("R11 done set", 32'(done), 32'd1);
    kick(0, 16'h0, 16'd4, 16'd2, 1'b0);
    chk("R11 div_zero cleared by start", 32'(div_zero), 32'd0);
    pulses(18, 0);
    chk("R11 no flag on nonzero divisor", 32'(div_zero), 32'd0);
    chk("R11 follow-up quotient", 32'(quotient), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule